// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the one-byte status word of a small serial memory and decides, every cycle, whether an array write at a given byte address and a status-word write are allowed. It holds a write-enable latch and a user flag (both volatile), a sticky protect-enable bit, and a two-bit lock code that selects which upper part of the array is read-only. The write-in-progress bit is copied from a busy input driven by the write engine.

The command decoder drives one strobe per decoded command. The write engine drives a busy level and a one-cycle pulse when a non-volatile cycle completes. The guard's permit outputs are combinational from its own flops and the current pin level and address, so the engine can sample them in the cycle it needs them. A synchronous reset models power-up. It clears the volatile bits and leaves the protection settings as they were.

Top module: `sr_guard_top`

## Requirements
- R1: The status byte is, from bit 7 down to bit 0: protect-enable, flag, 1, 1, lock[1], lock[0], write-enable latch, busy. Bits 5 and 4 always read 1.
- R2: Reset clears the write-enable latch, the flag and the busy copy. Protect-enable and the lock code keep their values through reset.
- R3: A cycle with `wren_stb` high and neither clear source high sets the write-enable latch, visible in the next cycle.
- R4: `wrdi_stb` clears both the latch and the flag. `cycle_done` clears the latch only. A clear source wins over `wren_stb` in the same cycle.
- R5: `sflb_stb` sets the flag unless `wrdi_stb` is high in the same cycle.
- R6: `stat_wr_ok` is high exactly when the latch is set and either protect-enable is 0 or `wp_pin` is high.
- R7: A `stat_wr_stb` cycle with `stat_wr_ok` high loads protect-enable from data bit 7 and the lock code from data bits 3:2. Data bits 6, 5, 4, 1 and 0 have no effect.
- R8: A `stat_wr_stb` cycle with `stat_wr_ok` low leaves protect-enable and the lock code unchanged.
- R9: With the default 12-bit address, lock code 00 protects nothing, 01 protects 0xC00–0xFFF, 10 protects 0x800–0xFFF and 11 protects every address.
- R10: `arr_wr_ok` is high exactly when the latch is set and the address is outside the protected range, whatever `wp_pin` and protect-enable are.
- R11: Status bit 0 follows `busy_in` one cycle later.
- R12: Once a status write has been accepted, a later fall of `wp_pin` does not undo it. It only refuses the status writes that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| wren_stb | input | 1 | Decoded set-latch command |
| wrdi_stb | input | 1 | Decoded clear-latch-and-flag command |
| sflb_stb | input | 1 | Decoded set-flag command |
| stat_wr_stb | input | 1 | Decoded status-write command with its data byte present |
| stat_wr_data | input | 8 | Status write data |
| cycle_done | input | 1 | One-cycle pulse from the write engine when a valid cycle ends |
| busy_in | input | 1 | Write engine busy level |
| wp_pin | input | 1 | External write-protect pin level (low = protect) |
| addr | input | ADDR_W | Byte address of the pending array write |
| status_q | output | 8 | Status byte |
| arr_wr_ok | output | 1 | Array write at `addr` permitted |
| stat_wr_ok | output | 1 | Status write permitted |

## Verification
The hardest state to reach is the locked one: protect-enable set and the pin low, which refuses every status write. It can only be entered through a status write accepted while the pin is high, with the pin dropped afterwards. The bench does this in that order and checks that the stored value survives the fall. It then tries a status write that must be refused, and checks that the lock code still gates array writes while the pin is low. Reset is applied afterwards to show that the locked state outlives power-up.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int STAT_W  = 8;
  localparam int B_PE    = 7;
  localparam int B_FLAG  = 6;
  localparam int B_LOCKH = 3;
  localparam int B_LOCKL = 2;
  localparam int B_WEL   = 1;
  localparam int B_BUSY  = 0;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } lock_e;

  typedef struct packed {
    logic  pe;
    lock_e lock;
  } nv_t;
endpackage

// File: rtl/sr_wel_flag.sv
module sr_wel_flag (
  input  logic clk,
  input  logic rst,
  input  logic wren_stb,
  input  logic wrdi_stb,
  input  logic sflb_stb,
  input  logic cycle_done,
  output logic wel_q,
  output logic flag_q
);
  logic clr_wel;
  assign clr_wel = wrdi_stb | cycle_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (clr_wel)       wel_q <= 1'b0;
      else if (wren_stb) wel_q <= 1'b1;
      if (wrdi_stb)      flag_q <= 1'b0;
      else if (sflb_stb) flag_q <= 1'b1;
    end
  end

  assert_wel_set_R3: assert property (@(posedge clk) disable iff (rst)
    (wren_stb && !wrdi_stb && !cycle_done) |=> wel_q);
  assert_wel_clr_R4: assert property (@(posedge clk) disable iff (rst)
    (wrdi_stb || cycle_done) |=> !wel_q);
  assert_flag_clr_R4: assert property (@(posedge clk) disable iff (rst)
    wrdi_stb |=> !flag_q);
  assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
    (sflb_stb && !wrdi_stb) |=> flag_q);
endmodule

// File: rtl/sr_nv_regs.sv
module sr_nv_regs
  import sr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic       permit,
  input  logic       d_pe,
  input  logic [1:0] d_lock,
  output nv_t        nv_q
);
  // Protection settings survive reset; the initial value stands for the
  // contents left in non-volatile storage.
  nv_t nv_r = '{pe: 1'b0, lock: LOCK_NONE};

  always_ff @(posedge clk) begin
    if (wr_stb && permit) begin
      nv_r.pe   <= d_pe;
      nv_r.lock <= lock_e'(d_lock);
    end
  end

  assign nv_q = nv_r;

  assert_nv_load_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && permit) |=> (nv_q.pe == $past(d_pe) && nv_q.lock == $past(d_lock)));
  assert_nv_refuse_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb && permit) |=> $stable(nv_q));
endmodule

// File: rtl/sr_lock_decode.sv
module sr_lock_decode
  import sr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  lock_e             lock,
  input  logic [ADDR_W-1:0] addr,
  output logic              prot
);
  localparam int TOP = ADDR_W - 1;
  localparam int NXT = ADDR_W - 2;

  logic in_upper_half;
  logic in_upper_quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_upper_half    = addr[TOP];
      assign in_upper_quarter = addr[TOP] & addr[NXT];
    end else begin : g_narrow
      assign in_upper_half    = addr[0];
      assign in_upper_quarter = addr[0];
    end
  endgenerate

  always_comb begin
    unique case (lock)
      LOCK_NONE:    prot = 1'b0;
      LOCK_QUARTER: prot = in_upper_quarter;
      LOCK_HALF:    prot = in_upper_half;
      default:      prot = 1'b1;
    endcase
  end

  always_comb begin
    if (lock == LOCK_NONE) assert_none_open_R9: assert (!prot);
    if (lock == LOCK_ALL)  assert_all_shut_R9: assert (prot);
  end
endmodule

// File: rtl/sr_guard_top.sv
module sr_guard_top
  import sr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              sflb_stb,
  input  logic              stat_wr_stb,
  input  logic [7:0]        stat_wr_data,
  input  logic              cycle_done,
  input  logic              busy_in,
  input  logic              wp_pin,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status_q,
  output logic              arr_wr_ok,
  output logic              stat_wr_ok
);
  logic wel_q;
  logic flag_q;
  logic busy_q;
  logic prot;
  nv_t  nv_q;
  logic unused_data_bits;

  assign unused_data_bits = ^{stat_wr_data[6:4], stat_wr_data[1:0]};

  sr_wel_flag u_wel (
    .clk        (clk),
    .rst        (rst),
    .wren_stb   (wren_stb),
    .wrdi_stb   (wrdi_stb),
    .sflb_stb   (sflb_stb),
    .cycle_done (cycle_done),
    .wel_q      (wel_q),
    .flag_q     (flag_q)
  );

  assign stat_wr_ok = wel_q & (~nv_q.pe | wp_pin);

  sr_nv_regs u_nv (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (stat_wr_stb),
    .permit (stat_wr_ok),
    .d_pe   (stat_wr_data[B_PE]),
    .d_lock (stat_wr_data[B_LOCKH:B_LOCKL]),
    .nv_q   (nv_q)
  );

  sr_lock_decode #(.ADDR_W(ADDR_W)) u_dec (
    .lock (nv_q.lock),
    .addr (addr),
    .prot (prot)
  );

  assign arr_wr_ok = wel_q & ~prot;

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_in;
  end

  always_comb begin
    status_q                  = '0;
    status_q[B_PE]            = nv_q.pe;
    status_q[B_FLAG]          = flag_q;
    status_q[5:4]             = 2'b11;
    status_q[B_LOCKH:B_LOCKL] = nv_q.lock;
    status_q[B_WEL]           = wel_q;
    status_q[B_BUSY]          = busy_q;
  end

  assert_const_bits_R1: assert property (@(posedge clk) disable iff (rst)
    status_q[5:4] == 2'b11);
  assert_no_permit_unlatched_R6: assert property (@(posedge clk) disable iff (rst)
    !status_q[B_WEL] |-> (!arr_wr_ok && !stat_wr_ok));
  assert_locked_refuse_R6: assert property (@(posedge clk) disable iff (rst)
    (status_q[B_PE] && !wp_pin) |-> !stat_wr_ok);
  assert_full_lock_R10: assert property (@(posedge clk) disable iff (rst)
    (status_q[B_LOCKH:B_LOCKL] == 2'b11) |-> !arr_wr_ok);
  assert_busy_follow_R11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> status_q[B_BUSY] == $past(busy_in));
endmodule

// File: tb/sim_sr_guard_top.sv
`timescale 1ns/100ps
module sim_sr_guard_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wren_stb = 0, wrdi_stb = 0, sflb_stb = 0, stat_wr_stb = 0;
  logic [7:0]  stat_wr_data = 0;
  logic        cycle_done = 0, busy_in = 0, wp_pin = 1;
  logic [11:0] addr = 0;
  logic [7:0]  status_q;
  logic        arr_wr_ok, stat_wr_ok;
  int          n_chk = 0, n_err = 0;
  bit          finished = 0;

  always #2.5 clk = ~clk;

  sr_guard_top #(.ADDR_W(12)) u0 (
    .clk(clk), .rst(rst), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .sflb_stb(sflb_stb), .stat_wr_stb(stat_wr_stb), .stat_wr_data(stat_wr_data),
    .cycle_done(cycle_done), .busy_in(busy_in), .wp_pin(wp_pin), .addr(addr),
    .status_q(status_q), .arr_wr_ok(arr_wr_ok), .stat_wr_ok(stat_wr_ok)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Strobes are driven just after a falling edge, held over one rising edge,
  // and released at the next falling edge, where results are sampled.
  task automatic cmd(input logic w, input logic d, input logic f, input logic c);
    wren_stb = w; wrdi_stb = d; sflb_stb = f; cycle_done = c;
    @(negedge clk);
    wren_stb = 0; wrdi_stb = 0; sflb_stb = 0; cycle_done = 0;
  endtask

  task automatic swr(input logic [7:0] d);
    stat_wr_stb = 1; stat_wr_data = d;
    @(negedge clk);
    stat_wr_stb = 0; stat_wr_data = 8'h00;
  endtask

  task automatic arr_at(input string req, input logic [11:0] a, input logic exp);
    addr = a; #0.5;
    chk(req, {7'd0, arr_wr_ok}, {7'd0, exp});
  endtask

  task automatic t_reset;
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    chk("R2 reset state", status_q, 8'h30);
  endtask

  task automatic t_latch_flag;
    cmd(1, 0, 0, 0); chk("R3 latch set", status_q, 8'h32);
    chk("R6 unlocked permit", {7'd0, stat_wr_ok}, 8'h01);
    cmd(0, 0, 1, 0); chk("R5 R1 flag set", status_q, 8'h72);
    cmd(0, 1, 0, 0); chk("R4 disable clears both", status_q, 8'h30);
    cmd(1, 0, 1, 0); cmd(0, 0, 0, 1);
    chk("R4 done clears latch only", status_q, 8'h70);
    cmd(1, 0, 0, 1); chk("R4 clear beats set", status_q, 8'h70);
    cmd(0, 1, 1, 0); chk("R5 disable beats flag set", status_q, 8'h30);
  endtask

  task automatic t_status_write;
    swr(8'h8C); chk("R8 refused without latch", status_q, 8'h30);
    cmd(1, 0, 0, 0); wp_pin = 1;
    swr(8'hFF); chk("R7 load pe and lock, others ignored", status_q, 8'hBE);
    wp_pin = 0; #0.5;
    chk("R6 locked refuses", {7'd0, stat_wr_ok}, 8'h00);
    @(negedge clk);
    swr(8'h00); chk("R8 refused when locked", status_q, 8'hBE);
    wp_pin = 1; #0.5;
    chk("R6 pin high permits", {7'd0, stat_wr_ok}, 8'h01);
    @(negedge clk);
  endtask

  task automatic t_decode;
    arr_at("R9 lock11 addr 000", 12'h000, 0);
    arr_at("R9 lock11 addr FFF", 12'hFFF, 0);
    @(negedge clk); swr(8'h84); chk("R7 lock01", status_q, 8'hB6);
    arr_at("R9 lock01 BFF", 12'hBFF, 1);
    arr_at("R9 lock01 C00", 12'hC00, 0);
    arr_at("R9 lock01 FFF", 12'hFFF, 0);
    wp_pin = 0;
    arr_at("R10 pin low unprotected", 12'h000, 1);
    wp_pin = 1;
    @(negedge clk); swr(8'h08); chk("R7 lock10", status_q, 8'h3A);
    arr_at("R9 lock10 7FF", 12'h7FF, 1);
    arr_at("R9 lock10 800", 12'h800, 0);
    @(negedge clk); swr(8'h00); chk("R7 lock00", status_q, 8'h32);
    arr_at("R9 lock00 FFF", 12'hFFF, 1);
    @(negedge clk); cmd(0, 1, 0, 0);
    arr_at("R10 no latch", 12'h000, 0);
    @(negedge clk);
  endtask

  task automatic t_pin_after;
    cmd(1, 0, 0, 0); wp_pin = 1;
    swr(8'h84); wp_pin = 0;
    @(negedge clk);
    chk("R12 accepted write kept", status_q, 8'hB6);
    swr(8'h00); chk("R12 later write refused", status_q, 8'hB6);
    arr_at("R12 lock still gates", 12'hC00, 0);
    arr_at("R10 pin low, pe set, unprotected", 12'h100, 1);
    @(negedge clk);
  endtask

  task automatic t_reset_keeps;
    cmd(0, 0, 1, 0);
    rst = 1; @(negedge clk); rst = 0;
    chk("R2 protection survives reset", status_q, 8'hB4);
  endtask

  task automatic t_busy;
    busy_in = 1; #0.5;
    chk("R11 busy not yet copied", {7'd0, status_q[0]}, 8'h00);
    @(negedge clk);
    chk("R11 busy copied", status_q, 8'hB5);
    busy_in = 0; @(negedge clk);
    chk("R11 busy released", {7'd0, status_q[0]}, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latch_flag();
    t_status_write();
    t_decode();
    t_pin_after();
    t_reset_keeps();
    t_busy();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule